// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K bytes. The host raises a request with a direction flag, an 18-bit byte address and, for stores, a data byte. The controller then runs the memory's control pins through a timed sequence and pulses a one-cycle completion strobe. After a load, the byte it fetched stays on the read-data port until the next load replaces it.

The memory is enabled only while an active-low select is low and an active-high select is high at the same time. Stores happen while write enable is low inside that window, with output enable held high. Loads happen with output enable low and write enable high. Each interval the memory requires (access time, write pulse, data overlap, select-to-end-of-write, cycle time, output float time) is given in nanoseconds for a speed bin of 70, 85 or 100 ns. The controller rounds each one up to whole clock cycles, using at least one cycle. The memory's data bus is shown as three ports: a byte the controller drives, that byte's drive enable, and the byte sampled from the pins.

Top module: `asram_ctrl`

## Requirements
- R1: While idle, including straight after reset, the controller holds the active-low select high, the active-high select low, output enable and write enable high (inactive) and its data drive off, and it shows ready.
- R2: A load keeps both selects active, output enable low and write enable high for exactly ACC cycles. ACC is the rounded-up maximum of the bin's access time and read cycle time (4 cycles at 20 ns and the 70 ns bin).
- R3: The byte on the memory data pins in the last cycle of a load's access window is shown on host read data when the completion strobe pulses, and it stays there until the next load.
- R4: After a load, the data drive stays off for at least TURN cycles after output enable returns high. TURN is the bin's output float time rounded up (2 cycles for the 70 ns bin).
- R5: The data drive is never on while output enable is low.
- R6: A store runs SETUP cycles with the selects active, data driven and write enable high (1 cycle). It then runs PULSE cycles with write enable low: the rounded-up maximum of pulse width, select-to-end and data overlap, 3 cycles for the 70 ns bin. Last come REC cycles with write enable high and data still driven: the larger of one cycle and the remainder of the write cycle time, 1 cycle for the 70 ns bin. Write enable is never low unless both selects are active.
- R7: The memory address equals the host address of the accepted request, and it does not change for as long as the access is in progress.
- R8: Each accepted request yields exactly one completion pulse, one cycle wide.
- R9: A request raised while the controller is busy (ready low) is ignored: it does not change memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, taken only while ready |
| host_we | input | 1 | 1 = store, 0 = load |
| host_addr | input | 18 | Byte address |
| host_wdata | input | 8 | Store data |
| host_rdata | output | 8 | Last loaded byte |
| host_done | output | 1 | One-cycle completion pulse |
| host_ready | output | 1 | Idle, can accept a request |
| mem_addr | output | 18 | Memory address pins |
| mem_sel_n | output | 1 | Active-low select |
| mem_sel | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Byte driven onto the data pins |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Byte sampled from the data pins |

## Verification
The assertions assume a synchronous, active-high reset and a memory that drives the data pins only while selected with output enable low, plus a short float time afterwards. The bench responder models exactly that: it keeps driving for one extra cycle after a load ends, which is within the turnaround window. It flags any cycle in which both sides drive. Requests are driven on falling edges and held only until accepted, except one deliberate request raised during a busy store to exercise the ignore rule.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_REC
  } asram_state_e;

  // Round a nanosecond interval up to clock cycles, never below one.
  function automatic int ns_cycles(int ns, int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Select one of three per-bin values (bin 0 = 70 ns, 1 = 85 ns, 2 = 100 ns).
  function automatic int by_bin(int bin, int v70, int v85, int v100);
    if (bin == 1) return v85;
    if (bin == 2) return v100;
    return v70;
  endfunction

  function automatic int rd_acc_cycles(int bin, int per);
    int t_cycle, t_access, t_oe;
    t_cycle  = by_bin(bin, 70, 85, 100);
    t_access = by_bin(bin, 70, 85, 100);
    t_oe     = by_bin(bin, 35, 40, 50);
    return imax(ns_cycles(t_cycle, per), imax(ns_cycles(t_access, per), ns_cycles(t_oe, per)));
  endfunction

  function automatic int turn_cycles(int bin, int per);
    return ns_cycles(by_bin(bin, 25, 25, 30), per);
  endfunction

  function automatic int wr_setup_cycles(int per);
    return ns_cycles(0, per);
  endfunction

  function automatic int wr_pulse_cycles(int bin, int per);
    int t_pulse, t_sel_end, t_overlap;
    t_pulse   = by_bin(bin, 55, 60, 70);
    t_sel_end = by_bin(bin, 60, 70, 80);
    t_overlap = by_bin(bin, 30, 35, 40);
    return imax(ns_cycles(t_pulse, per), imax(ns_cycles(t_sel_end, per), ns_cycles(t_overlap, per)));
  endfunction

  function automatic int wr_rec_cycles(int bin, int per);
    int rest;
    rest = ns_cycles(by_bin(bin, 70, 85, 100), per) - wr_setup_cycles(per) - wr_pulse_cycles(bin, per);
    return imax(ns_cycles(0, per), rest);
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int ACC_C    = 4,
  parameter int TURN_C   = 2,
  parameter int SETUP_C  = 1,
  parameter int PULSE_C  = 3,
  parameter int REC_C    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_we,
  input  logic             t_zero,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output asram_state_e     state_d,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             done
);
  asram_state_e state_q;
  logic         done_q;
  logic         last_cycle;

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    case (state_q)
      ST_IDLE: if (req) begin
        t_load = 1'b1;
        if (req_we) begin
          state_d = ST_WR_SETUP;
          t_val   = CNT_W'(SETUP_C - 1);
        end else begin
          state_d = ST_RD_ACC;
          t_val   = CNT_W'(ACC_C - 1);
        end
      end
      ST_RD_ACC: if (t_zero) begin
        state_d = ST_RD_TURN;
        t_load  = 1'b1;
        t_val   = CNT_W'(TURN_C - 1);
      end
      ST_RD_TURN: if (t_zero) state_d = ST_IDLE;
      ST_WR_SETUP: if (t_zero) begin
        state_d = ST_WR_PULSE;
        t_load  = 1'b1;
        t_val   = CNT_W'(PULSE_C - 1);
      end
      ST_WR_PULSE: if (t_zero) begin
        state_d = ST_WR_REC;
        t_load  = 1'b1;
        t_val   = CNT_W'(REC_C - 1);
      end
      ST_WR_REC: if (t_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign last_cycle = t_zero && (state_q == ST_RD_TURN || state_q == ST_WR_REC);
  assign accept     = (state_q == ST_IDLE) && req;
  assign capture    = (state_q == ST_RD_ACC) && t_zero;
  assign ready      = (state_q == ST_IDLE);
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last_cycle;
    end
  end

  // R8: completion is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: a pulse is only produced once an access has left the idle state
  assert_done_after_work_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(!ready));
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  asram_state_e state_d,
  output logic         sel_n,
  output logic         sel,
  output logic         oe_n,
  output logic         we_n,
  output logic         dq_oe
);
  logic sel_d, oe_d, we_d, drv_d;

  always_comb begin
    sel_d = 1'b0;
    oe_d  = 1'b0;
    we_d  = 1'b0;
    drv_d = 1'b0;
    case (state_d)
      ST_RD_ACC:   begin sel_d = 1'b1; oe_d = 1'b1; end
      ST_WR_SETUP: begin sel_d = 1'b1; drv_d = 1'b1; end
      ST_WR_PULSE: begin sel_d = 1'b1; drv_d = 1'b1; we_d = 1'b1; end
      ST_WR_REC:   begin sel_d = 1'b1; drv_d = 1'b1; end
      default: ;
    endcase
  end

  // Pins come straight from flops so the memory never sees decode glitches.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_n <= 1'b1;
      sel   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      sel_n <= ~sel_d;
      sel   <= sel_d;
      oe_n  <= ~oe_d;
      we_n  <= ~we_d;
      dq_oe <= drv_d;
    end
  end

  // R5: no drive while the memory may be driving
  assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !dq_oe);
  // R6: write enable only inside the selected window, with data driven
  assert_write_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!sel_n && sel && oe_n && dq_oe));
  // R6: write enable ends while the selects and data stay up (recovery)
  assert_write_recovery_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (!sel_n && sel && dq_oe));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int SPEED_BIN = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic              host_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int ACC_C   = rd_acc_cycles(SPEED_BIN, CLK_NS);
  localparam int TURN_C  = turn_cycles(SPEED_BIN, CLK_NS);
  localparam int SETUP_C = wr_setup_cycles(CLK_NS);
  localparam int PULSE_C = wr_pulse_cycles(SPEED_BIN, CLK_NS);
  localparam int REC_C   = wr_rec_cycles(SPEED_BIN, CLK_NS);
  localparam int MAX_C   = imax(imax(ACC_C, TURN_C), imax(imax(SETUP_C, PULSE_C), REC_C));
  localparam int CNT_W   = $clog2(MAX_C + 1);
  localparam int GAP_W   = $clog2(TURN_C + 2);

  logic             t_load, t_zero, accept, capture;
  logic [CNT_W-1:0] t_val;
  asram_state_e     state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .at_zero(t_zero)
  );

  asram_seq #(
    .CNT_W(CNT_W), .ACC_C(ACC_C), .TURN_C(TURN_C),
    .SETUP_C(SETUP_C), .PULSE_C(PULSE_C), .REC_C(REC_C)
  ) u_seq (
    .clk(clk), .rst(rst), .req(host_req), .req_we(host_we),
    .t_zero(t_zero), .t_load(t_load), .t_val(t_val), .state_d(state_d),
    .accept(accept), .capture(capture), .ready(host_ready), .done(host_done)
  );

  asram_pins u_pins (
    .clk(clk), .rst(rst), .state_d(state_d),
    .sel_n(mem_sel_n), .sel(mem_sel), .oe_n(mem_oe_n),
    .we_n(mem_we_n), .dq_oe(mem_dq_oe)
  );

  // Request fields are latched once, on acceptance, and held for the access.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= host_addr;
        wdata_q <= host_wdata;
      end
      if (capture) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_o   = wdata_q;
  assign host_rdata = rdata_q;

  // Cycles since output enable was last low, saturating; used by R4 check.
  logic [GAP_W-1:0] oe_gap_q;
  always_ff @(posedge clk) begin
    if (rst)                       oe_gap_q <= GAP_W'(TURN_C);
    else if (!mem_oe_n)            oe_gap_q <= '0;
    else if (oe_gap_q < GAP_W'(TURN_C)) oe_gap_q <= oe_gap_q + 1'b1;
  end

  // R4: bus drive starts only after the float window has elapsed
  assert_turnaround_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_gap_q >= GAP_W'(TURN_C)));
  // R7: address frozen while busy
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!host_ready && $past(!host_ready)) |-> $stable(mem_addr));
  // R1: idle means the memory is deselected and the bus is released
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        host_req = 1'b0, host_we = 1'b0;
  logic [17:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_done, host_ready;
  logic [17:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  asram_ctrl u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .host_ready(host_ready), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // Expected cycle counts: smallest k >= 1 with k * 20 ns covering the interval.
  function automatic int need(int ns);
    int k = 1;
    while (k * 20 < ns) k++;
    return k;
  endfunction
  int ACC, TURN, SETUP, PULSE, REC;

  int nvec = 0, nfail = 0, ndone = 0, nissued = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory responder ----------------
  logic [7:0] bmem [int];
  function automatic logic [7:0] init_val(logic [17:0] a);
    return a[7:0] ^ a[17:10] ^ 8'hA5;
  endfunction
  wire  selected = !mem_sel_n && mem_sel;
  wire  rd_now   = selected && !mem_oe_n && mem_we_n;
  logic rd_hold = 1'b0;
  logic [17:0] rd_addr = '0;
  wire  mem_drv = rd_now || rd_hold;
  logic [7:0] rd_byte;
  always_comb begin
    logic [17:0] a;
    a = rd_now ? mem_addr : rd_addr;
    rd_byte = bmem.exists(int'(a)) ? bmem[int'(a)] : init_val(a);
  end
  assign mem_dq_i = mem_drv ? rd_byte : (mem_dq_oe ? mem_dq_o : 8'h00);
  always @(posedge clk) begin
    rd_hold <= rd_now;
    if (rd_now) rd_addr <= mem_addr;
    if (selected && !mem_we_n) bmem[int'(mem_addr)] = mem_dq_o;
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit rd; logic [17:0] a; logic [7:0] d; } item_t;
  item_t expq[$];
  logic [7:0] shadow [int];

  task automatic issue(input bit w, input logic [17:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
    if (w) shadow[int'(a)] = d;
    it.rd = !w; it.a = a;
    it.d = shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
    expq.push_back(it);
    nissued++;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  // ---------------- monitor ----------------
  int  hi_run = 0, lo_run = 0, oe_run = 0, oe_gap = 99;
  bit  p_we = 1, p_dq = 0, p_oe = 1, p_done = 0;
  always @(negedge clk) if (!rst && !finished) begin
    if (host_done) begin
      item_t it;
      ndone++;
      if (expq.size() == 0) chk(0, "R8 spurious done", 1, 0);
      else begin
        it = expq.pop_front();
        if (it.rd) chk(host_rdata == it.d, "R3 read data", host_rdata, it.d);
      end
    end
    if (host_done && p_done) chk(0, "R8 done width", 2, 1);
    if (!mem_we_n && p_we) begin
      chk(hi_run == SETUP, "R6 setup", hi_run, SETUP);
      if (expq.size() > 0) chk(mem_addr == expq[0].a, "R7 write addr", mem_addr, expq[0].a);
    end
    if (mem_we_n && !p_we) chk(lo_run == PULSE, "R6 pulse", lo_run, PULSE);
    if (!mem_we_n) chk(selected && mem_oe_n, "R6 window", {selected, mem_oe_n}, 2'b11);
    if (!mem_dq_oe && p_dq) chk(hi_run == REC, "R6 recovery", hi_run, REC);
    if (mem_oe_n && !p_oe) begin
      chk(oe_run == ACC, "R2 access", oe_run, ACC);
      if (expq.size() > 0) chk(mem_addr == expq[0].a, "R7 read addr", mem_addr, expq[0].a);
    end
    if (!mem_oe_n) chk(selected && mem_we_n, "R2 select", {selected, mem_we_n}, 2'b11);
    if (mem_dq_oe && !p_dq) chk(oe_gap >= TURN, "R4 turnaround", oe_gap, TURN);
    if (mem_dq_oe && mem_drv) chk(0, "R5 contention", 1, 0);
    hi_run = (mem_dq_oe && mem_we_n) ? hi_run + 1 : 0;
    lo_run = !mem_we_n ? lo_run + 1 : 0;
    oe_run = !mem_oe_n ? oe_run + 1 : 0;
    oe_gap = mem_oe_n ? oe_gap + 1 : 0;
    p_we = mem_we_n; p_dq = mem_dq_oe; p_oe = mem_oe_n; p_done = host_done;
  end

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    ACC = need(70); TURN = need(25); SETUP = need(0);
    PULSE = need(60); REC = need(70) - SETUP - PULSE;
    if (REC < 1) REC = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1: reset / idle state
    chk(mem_sel_n && !mem_sel, "R1 selects idle", {mem_sel_n, mem_sel}, 2'b10);
    chk(mem_oe_n && mem_we_n, "R1 enables idle", {mem_oe_n, mem_we_n}, 2'b11);
    chk(!mem_dq_oe && host_ready && !host_done, "R1 bus/ready", {mem_dq_oe, host_ready, host_done}, 3'b010);

    issue(0, 18'h00010, 8'h00);          // read of untouched location
    issue(1, 18'h00010, 8'h3C);          // write right after read: R4 turnaround
    issue(0, 18'h00010, 8'h00);
    issue(1, 18'h3FFFF, 8'hFF);          // top address
    issue(1, 18'h00000, 8'h00);          // bottom address
    issue(0, 18'h3FFFF, 8'h00);
    issue(0, 18'h00000, 8'h00);
    for (int i = 0; i < 6; i++) issue(1, 18'(20 + i * 4099), 8'(i * 37 + 1));
    for (int i = 0; i < 6; i++) issue(0, 18'(20 + i * 4099), 8'h00);   // back-to-back reads

    // R9: a request raised while a write is busy is ignored
    issue(1, 18'h00005, 8'h11);
    @(negedge clk);
    chk(!host_ready, "R9 busy", host_ready, 0);
    host_req = 1'b1; host_we = 1'b1; host_addr = 18'h00006; host_wdata = 8'h22;
    @(negedge clk);
    host_req = 1'b0;
    issue(0, 18'h00006, 8'h00);          // must return the untouched value
    issue(0, 18'h00005, 8'h00);

    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ndone == nissued, "R8 done count", ndone, nissued);
    chk(host_ready && mem_sel_n && !mem_dq_oe, "R1 idle after run", {host_ready, mem_sel_n, mem_dq_oe}, 3'b110);
    finish_run();
  end
endmodule